// File: doc/BRIEF.md
# Disc Track Sync Deframer

This block sits behind a disc read channel that has already recovered a serial bit stream. After a start command it waits for the index pulse to fall, then searches the incoming bits for a preamble pattern. Only once that pattern has been seen does it look for the sync word. After the sync word, every following group of sixteen bits is one recording cell. The block keeps the odd-positioned bits of each cell to form a data byte and writes that byte to a buffer RAM.

The buffer can be filled in two ways. In contiguous mode every byte lands at the next address. In stride-2 mode only every other byte is kept, and it is packed at half the running byte count. A track has two sides. Side 0 ends when the running byte count reaches its quota. The block then selects side 1 and waits for the next index fall. The command completes when the count reaches the side-1 quota.

The control is a four-state machine:
- IDLE: after reset.
- ARMED: waiting for the index pulse to fall. START enters ARMED from any state.
- READ: the stream is being consumed. INDEX_FALL moves ARMED to READ while fewer than two sides have been read.
- DONE: the command has completed.

From READ, SIDE0_FULL returns to ARMED with side 1 selected, and SIDE1_FULL moves to DONE.

Top module: `trk_deframer`

## Requirements
- R1: After reset the block is idle: busy, done, side_sel and ram_we are all 0.
- R2: Each accepted bit enters a 16-bit window at bit 0, and older bits move toward bit 15. The first bit of a cell therefore ends up at window bit 15.
- R3: The sync word 0x9125 is recognised only after the preamble 0xAAAA has matched. A sync word received before the preamble produces no writes.
- R4: After the sync word, each 16 bits form one byte from window bits 15,13,11,9,7,5,3,1, with bit 15 as the byte MSB. The even window bits have no effect on the byte.
- R5: On a preamble match, on a sync match and after each byte, the window and the bit count return to zero. The first data cell therefore starts with the bit right after the sync word.
- R6: In contiguous mode (stride_mode=0 at start), byte n of the command is written to ram_addr n. A write appears on ram_we two clock edges after the last bit of its cell.
- R7: In stride-2 mode (stride_mode=1 at start), the byte count still advances for every byte. Only bytes with an even count are written, at ram_addr equal to the count shifted right by one.
- R8: When the byte count reaches SIDE0_LIMIT, side_sel becomes 1 and busy stays 1. Bits are then ignored until the next falling edge of index_in.
- R9: When the byte count reaches SIDE1_LIMIT, done becomes 1 and busy becomes 0. Later bits cause no writes.
- R10: Reading begins only on a falling edge of index_in while a command is pending and fewer than two sides are read. Bits sent before that edge have no effect.
- R11: A start pulse clears the side, the byte count and the pattern search, drops done, and raises busy. This also applies in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command pulse |
| stride_mode | input | 1 | Buffer mode sampled at start: 0 contiguous, 1 stride-2 |
| index_in | input | 1 | Index pulse from the drive; its falling edge begins a side |
| bit_valid | input | 1 | bit_in carries a recovered bit this cycle |
| bit_in | input | 1 | Recovered serial data bit |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_addr | output | ADDR_W | Buffer RAM write address |
| ram_data | output | 8 | Buffer RAM write data |
| side_sel | output | 1 | Head side select, 1 once side 0 is complete |
| busy | output | 1 | A command is in progress |
| done | output | 1 | The command has read both sides |

## Verification
The hardest situation to reach from the ports is the gap between sides. Side 0 has met its quota, side_sel has switched, and a well-formed preamble, sync and data cell arrive before the index pulse falls again. To reach it, the stimulus fills side 0 exactly to a small quota set by parameter, then sends a complete framed byte while index_in is still high. Only after that does it drop index_in. Any write in that window has no expected entry in the scoreboard and is reported. The same technique covers three other cases: a sync word sent ahead of its preamble, bits sent before the first index fall, and a restart issued in the middle of a read.

// File: rtl/trk_deframe_pkg.sv
package trk_deframe_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_READ, ST_DONE} rd_state_e;
    localparam int          CELL_BITS    = 16;
    localparam logic [15:0] PREAMBLE_PAT = 16'hAAAA;
    localparam logic [15:0] SYNC_PAT     = 16'h9125;
endpackage

// File: rtl/cell_hunter.sv
module cell_hunter
    import trk_deframe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       shift_en,
    input  logic       bit_in,
    output logic       byte_vld,
    output logic [7:0] byte_out
);
    localparam int CNT_W = $clog2(CELL_BITS);

    logic [CELL_BITS-1:0] win_q, win_nxt;
    logic [CNT_W-1:0]     cnt_q;
    logic                 pre_seen_q, in_data_q;
    logic [7:0]           odd_bits;

    assign win_nxt = {win_q[CELL_BITS-2:0], bit_in};

    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_odd
            assign odd_bits[g] = win_nxt[2*g+1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            cnt_q      <= '0;
            pre_seen_q <= 1'b0;
            in_data_q  <= 1'b0;
            byte_vld   <= 1'b0;
            byte_out   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (clr) begin
                win_q      <= '0;
                cnt_q      <= '0;
                pre_seen_q <= 1'b0;
                in_data_q  <= 1'b0;
            end else if (shift_en) begin
                if (!pre_seen_q && win_nxt == PREAMBLE_PAT) begin
                    pre_seen_q <= 1'b1;
                    win_q      <= '0;
                    cnt_q      <= '0;
                end else if (pre_seen_q && !in_data_q && win_nxt == SYNC_PAT) begin
                    in_data_q <= 1'b1;
                    win_q     <= '0;
                    cnt_q     <= '0;
                end else if (in_data_q && cnt_q == CNT_W'(CELL_BITS - 1)) begin
                    byte_vld <= 1'b1;
                    byte_out <= odd_bits;
                    win_q    <= '0;
                    cnt_q    <= '0;
                end else begin
                    win_q <= win_nxt;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    p_sync_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data_q) |-> $past(pre_seen_q));

    p_byte_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(in_data_q));
endmodule

// File: rtl/buf_writer.sv
module buf_writer #(
    parameter int ADDR_W      = 16,
    parameter int SIDE0_LIMIT = 32'h2700,
    parameter int SIDE1_LIMIT = 32'h4800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stride,
    input  logic [1:0]        side,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data,
    output logic              quota_hit
);
    localparam logic [ADDR_W:0] LIM0 = (ADDR_W+1)'(SIDE0_LIMIT);
    localparam logic [ADDR_W:0] LIM1 = (ADDR_W+1)'(SIDE1_LIMIT);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W:0]   addr_inc;
    logic              keep;

    assign addr_inc  = {1'b0, addr_q} + 1'b1;
    assign keep      = !stride || !addr_q[0];
    assign quota_hit = byte_vld && (addr_inc >= ((side == 2'd0) ? LIM0 : LIM1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= 1'b0;
            if (clr) begin
                addr_q <= '0;
            end else if (byte_vld) begin
                addr_q <= addr_inc[ADDR_W-1:0];
                if (keep) begin
                    ram_we   <= 1'b1;
                    ram_addr <= stride ? (addr_q >> 1) : addr_q;
                    ram_data <= byte_in;
                end
            end
        end
    end

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !clr) |=> (addr_q == $past(addr_q) + 1'b1));

    p_we_follows_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(byte_vld));
endmodule

// File: rtl/trk_deframer.sv
module trk_deframer
    import trk_deframe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SIDE0_LIMIT = 32'h2700,
    parameter int SIDE1_LIMIT = 32'h4800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stride_mode,
    input  logic              index_in,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data,
    output logic              side_sel,
    output logic              busy,
    output logic              done
);
    rd_state_e  state_q, state_nxt;
    logic [1:0] side_q;
    logic       stride_q, idx_q;
    logic       idx_fall, go_read, quota_hit, byte_vld;
    logic [7:0] byte_w;

    assign idx_fall = idx_q && !index_in;
    assign go_read  = (state_q == ST_ARMED) && idx_fall && (side_q < 2'd2) && !start;

    always_comb begin
        state_nxt = state_q;
        if (start) begin
            state_nxt = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_ARMED: if (go_read) state_nxt = ST_READ;
                ST_READ:  if (quota_hit) state_nxt = (side_q == 2'd0) ? ST_ARMED : ST_DONE;
                ST_DONE:  state_nxt = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            side_q   <= 2'd0;
            stride_q <= 1'b0;
            idx_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            idx_q   <= index_in;
            if (start) begin
                side_q   <= 2'd0;
                stride_q <= stride_mode;
            end else if (state_q == ST_READ && quota_hit) begin
                side_q <= side_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy     = (state_q == ST_ARMED) || (state_q == ST_READ);
        done     = (state_q == ST_DONE);
        side_sel = (side_q != 2'd0);
    end

    cell_hunter u_hunter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start || go_read),
        .shift_en (bit_valid && state_q == ST_READ),
        .bit_in   (bit_in),
        .byte_vld (byte_vld),
        .byte_out (byte_w)
    );

    buf_writer #(
        .ADDR_W      (ADDR_W),
        .SIDE0_LIMIT (SIDE0_LIMIT),
        .SIDE1_LIMIT (SIDE1_LIMIT)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .stride    (stride_q),
        .side      (side_q),
        .byte_vld  (byte_vld),
        .byte_in   (byte_w),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_data  (ram_data),
        .quota_hit (quota_hit)
    );

    p_we_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(state_q == ST_READ));

    p_read_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) == ST_ARMED) |-> $past(idx_fall));

    p_done_after_side1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(side_q) == 2'd1));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !ram_we);
endmodule

// File: tb/tb_trk_deframer.sv
module tb_trk_deframer;
    localparam int ADDR_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stride_mode = 1'b0, index_in = 1'b0;
    logic bit_valid = 1'b0, bit_in = 1'b0;
    logic ram_we, side_sel, busy, done;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0] ram_data;

    int n_chk = 0, n_fail = 0;
    int exp_idx = 0;
    logic mode_s = 1'b0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    trk_deframer #(.ADDR_W(ADDR_W), .SIDE0_LIMIT(6), .SIDE1_LIMIT(10)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stride_mode(stride_mode),
        .index_in(index_in), .bit_valid(bit_valid), .bit_in(bit_in),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
        .side_sel(side_sel), .busy(busy), .done(done));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3/R8/R9/R10 unexpected write actual=%0h expected=none",
                         {ram_addr, ram_data});
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk("R6/R7 write address", 32'(ram_addr), 32'(e[23:8]));
                chk("R2/R4/R5 write data", 32'(ram_data), 32'(e[7:0]));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1;
        bit_in = b;
        tick(1);
        bit_valid = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    // one cell: data bit at odd window position, complement at even position
    task automatic send_cell(input logic [7:0] d);
        for (int k = 7; k >= 0; k--) begin
            send_bit(d[k]);
            send_bit(~d[k]);
        end
    endtask

    task automatic send_data(input logic [7:0] d);
        if (!mode_s) exp_q.push_back({16'(exp_idx), d});
        else if ((exp_idx % 2) == 0) exp_q.push_back({16'(exp_idx / 2), d});
        exp_idx++;
        send_cell(d);
    endtask

    task automatic do_start(input logic s);
        start = 1'b1;
        stride_mode = s;
        tick(1);
        start = 1'b0;
        mode_s = s;
        exp_idx = 0;
    endtask

    task automatic index_fall();
        index_in = 1'b1;
        tick(2);
        index_in = 1'b0;
        tick(1);
    endtask

    task automatic frame_head();
        repeat (5) send_bit(1'b0);
        send_word(16'hAAAA);
        send_word(16'h9125);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 side_sel", 32'(side_sel), 0);
        chk("R1 ram_we", 32'(ram_we), 0);

        // contiguous run
        do_start(1'b0);
        chk("R11 busy after start", 32'(busy), 1);
        chk("R11 done after start", 32'(done), 0);
        // R10: framed data before the index edge is ignored
        frame_head();
        send_cell(8'hEE);
        index_in = 1'b1;
        tick(2);
        send_cell(8'h11);
        index_in = 1'b0;
        tick(1);
        // R3: sync without preamble is ignored
        repeat (5) send_bit(1'b0);
        send_word(16'h9125);
        send_cell(8'h00);
        send_word(16'hAAAA);
        send_word(16'h9125);
        send_data(8'h80);
        send_data(8'h01);
        send_data(8'hA5);
        send_data(8'h5A);
        send_data(8'hFF);
        send_data(8'h3C);
        tick(3);
        chk("R8 side_sel after side0", 32'(side_sel), 1);
        chk("R8 busy after side0", 32'(busy), 1);
        chk("R8 done after side0", 32'(done), 0);
        // R8: full frame before next index fall is ignored
        frame_head();
        send_cell(8'h77);
        index_fall();
        frame_head();
        send_data(8'h12);
        send_data(8'h34);
        send_data(8'hC3);
        send_data(8'h00);
        tick(3);
        chk("R9 done", 32'(done), 1);
        chk("R9 busy", 32'(busy), 0);
        send_cell(8'h99);
        frame_head();
        send_cell(8'h42);
        tick(3);
        chk("R9 queue drained", 32'(exp_q.size()), 0);

        // stride-2 run
        do_start(1'b1);
        chk("R11 done cleared", 32'(done), 0);
        chk("R11 side cleared", 32'(side_sel), 0);
        index_fall();
        frame_head();
        for (int i = 0; i < 6; i++) send_data(8'(8'h21 + 8'(i * 17)));
        tick(3);
        chk("R7 side_sel after side0", 32'(side_sel), 1);
        index_fall();
        frame_head();
        for (int i = 0; i < 4; i++) send_data(8'(8'h90 + 8'(i * 3)));
        tick(3);
        chk("R7 done", 32'(done), 1);
        chk("R7 queue drained", 32'(exp_q.size()), 0);

        // restart in mid-read
        do_start(1'b0);
        index_fall();
        frame_head();
        send_data(8'hAB);
        send_data(8'hCD);
        tick(3);
        do_start(1'b0);
        chk("R11 busy on restart", 32'(busy), 1);
        chk("R11 side on restart", 32'(side_sel), 0);
        index_fall();
        frame_head();
        for (int i = 0; i < 6; i++) send_data(8'(8'h40 + 8'(i)));
        tick(3);
        chk("R11 side0 quota from zero", 32'(side_sel), 1);
        chk("R11 queue drained", 32'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule